// File: doc/BRIEF.md
# Data Breakpoint Address Matcher

This block watches the data accesses of a processor pipeline and flags any load or store whose address falls inside one of a small set of programmed watch regions. Each watch slot has an address register and a control register. The control register enables matching of loads, stores or both, and gives a six-bit mask field that selects how many low address bits are ignored. The region is a power-of-two block aligned to its own size.

The control path writes one register of one slot per cycle through a plain write strobe. The access path carries a valid strobe, the address and a load/store flag. The hit outputs are a purely combinational function of that access and the stored slot state, so a hit is known in the same cycle the access is presented, before the access takes effect. The access port has no ready signal. The matcher never stalls, so there is no back-pressure: every cycle with the valid strobe high is evaluated on its own.

A mask field whose set bits are not one unbroken run from its top bit is trimmed on write. The trimmed field keeps the run of ones that starts at bit 5 and stops at the first zero. Every bit below that zero is cleared, which widens the region.

Top module: `dbm_watch`

## Requirements
- R1: After reset every slot has both enables clear, so no access raises any hit until a control register is written.
- R2: A slot whose control value has both bit 31 (store enable) and bit 30 (load enable) clear never hits.
- R3: A store access (acc_store=1) can hit slot i only when bit 31 of that slot's control value is set.
- R4: A load access (acc_store=0) can hit slot i only when bit 30 of that slot's control value is set.
- R5: With effective mask M equal to all ones above bit 5 and the trimmed control bits 5:0 below, an enabled access hits slot i exactly when (acc_addr AND M) equals (slot address AND M). Field 6'h3F matches one byte address, and field 6'h00 matches a 64-byte block.
- R6: A mask field that is not ones from bit 5 down followed by zeros is trimmed to its leading ones from bit 5. For example, 6'b110101 acts as 6'b110000, a 16-byte region.
- R7: While acc_valid is low, hit_vec and hit_any are zero.
- R8: hit_any is high exactly when at least one bit of hit_vec is high, and several slots may hit together.
- R9: A register write (cfg_we, cfg_idx, cfg_sel_ctrl=1 for control, 0 for address) changes matching from the cycle after the write edge. An access in the same cycle as the write sees the old value.
- R10: A write changes only the addressed register of the addressed slot. The other register of that slot and all other slots keep their values.
- R11: Hits are produced in the same cycle as the access with no register on the path.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_idx | input | max(1,clog2(NUM_BP)) | Slot selected for the write |
| cfg_sel_ctrl | input | 1 | 1 writes the control register, 0 writes the address register |
| cfg_wdata | input | ADDR_W | Write data |
| acc_valid | input | 1 | Access present this cycle |
| acc_addr | input | ADDR_W | Access address |
| acc_store | input | 1 | 1 for a store, 0 for a load |
| hit_vec | output | NUM_BP | Per-slot hit for the current access |
| hit_any | output | 1 | OR of all slot hits |

## Verification
Hit outputs are due in the same cycle as the access. The bench therefore drives each access on the falling edge and samples one time step later, before the next rising edge. A register write becomes visible one rising edge after the strobe. The bench updates its own model only after that edge, and in one directed case it samples both in the write cycle, expecting the old value, and in the following cycle, expecting the new value.

// File: rtl/dbm_pkg.sv
package dbm_pkg;

  // Which register of a slot a configuration write targets.
  typedef enum logic {
    CFG_TGT_ADDR = 1'b0,
    CFG_TGT_CTRL = 1'b1
  } cfg_tgt_e;

  // Access direction as carried on acc_store.
  typedef enum logic {
    ACC_LOAD  = 1'b0,
    ACC_STORE = 1'b1
  } acc_kind_e;

  // Offsets of the enable bits counted down from the top of the control word.
  localparam int unsigned ST_EN_FROM_TOP = 1;
  localparam int unsigned LD_EN_FROM_TOP = 2;

endpackage

// File: rtl/dbm_mask_trim.sv
// Keeps the run of ones that starts at the top bit of the mask field and
// clears every bit below the first zero.
module dbm_mask_trim #(
  parameter int unsigned MASK_W = 6
) (
  input  logic [MASK_W-1:0] field_in,
  output logic [MASK_W-1:0] field_out
);

  logic [MASK_W:0] run;

  assign run[MASK_W] = 1'b1;

  for (genvar b = MASK_W - 1; b >= 0; b--) begin : g_run
    assign run[b]       = run[b+1] & field_in[b];
    assign field_out[b] = run[b];
  end

endmodule

// File: rtl/dbm_slot.sv
// Storage for one watch slot: address, enables and the trimmed mask field.
module dbm_slot
  import dbm_pkg::*;
#(
  parameter int unsigned ADDR_W = 32,
  parameter int unsigned MASK_W = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_addr,
  input  logic              wr_ctrl,
  input  logic [ADDR_W-1:0] wdata,
  output logic [ADDR_W-1:0] bp_addr,
  output logic [ADDR_W-1:0] bp_mask,
  output logic              bp_st_en,
  output logic              bp_ld_en
);

  localparam int unsigned ST_BIT = ADDR_W - ST_EN_FROM_TOP;
  localparam int unsigned LD_BIT = ADDR_W - LD_EN_FROM_TOP;
  localparam int unsigned HI_W   = ADDR_W - MASK_W;

  logic [MASK_W-1:0] trimmed;
  logic [MASK_W-1:0] mask_q;
  logic [ADDR_W-1:0] addr_q;
  logic              st_q;
  logic              ld_q;

  dbm_mask_trim #(.MASK_W(MASK_W)) u_trim (
    .field_in  (wdata[MASK_W-1:0]),
    .field_out (trimmed)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      addr_q <= '0;
    end else if (wr_addr) begin
      addr_q <= wdata;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mask_q <= '0;
      st_q   <= 1'b0;
      ld_q   <= 1'b0;
    end else if (wr_ctrl) begin
      mask_q <= trimmed;
      st_q   <= wdata[ST_BIT];
      ld_q   <= wdata[LD_BIT];
    end
  end

  assign bp_addr  = addr_q;
  assign bp_mask  = {{HI_W{1'b1}}, mask_q};
  assign bp_st_en = st_q;
  assign bp_ld_en = ld_q;

endmodule

// File: rtl/dbm_match.sv
// Combinational comparison of one access against one slot.
module dbm_match
  import dbm_pkg::*;
#(
  parameter int unsigned ADDR_W = 32
) (
  input  logic              acc_valid,
  input  logic [ADDR_W-1:0] acc_addr,
  input  logic              acc_store,
  input  logic [ADDR_W-1:0] bp_addr,
  input  logic [ADDR_W-1:0] bp_mask,
  input  logic              bp_st_en,
  input  logic              bp_ld_en,
  output logic              hit
);

  logic dir_ok;
  logic addr_eq;

  always_comb begin
    dir_ok  = (acc_kind_e'(acc_store) == ACC_STORE) ? bp_st_en : bp_ld_en;
    addr_eq = (((acc_addr ^ bp_addr) & bp_mask) == '0);
    hit     = acc_valid & dir_ok & addr_eq;
  end

endmodule

// File: rtl/dbm_watch.sv
module dbm_watch
  import dbm_pkg::*;
#(
  parameter int unsigned NUM_BP = 2,
  parameter int unsigned ADDR_W = 32,
  parameter int unsigned MASK_W = 6
) (
  input  logic                                       clk,
  input  logic                                       rst_n,
  input  logic                                       cfg_we,
  input  logic [$clog2(NUM_BP > 1 ? NUM_BP : 2)-1:0] cfg_idx,
  input  logic                                       cfg_sel_ctrl,
  input  logic [ADDR_W-1:0]                          cfg_wdata,
  input  logic                                       acc_valid,
  input  logic [ADDR_W-1:0]                          acc_addr,
  input  logic                                       acc_store,
  output logic [NUM_BP-1:0]                          hit_vec,
  output logic                                       hit_any
);

  localparam int unsigned IDX_W = $clog2(NUM_BP > 1 ? NUM_BP : 2);

  for (genvar i = 0; i < NUM_BP; i++) begin : g_slot
    logic              sel;
    logic [ADDR_W-1:0] s_addr;
    logic [ADDR_W-1:0] s_mask;
    logic              s_st;
    logic              s_ld;

    assign sel = cfg_we && (cfg_idx == IDX_W'(i));

    dbm_slot #(.ADDR_W(ADDR_W), .MASK_W(MASK_W)) u_slot (
      .clk      (clk),
      .rst_n    (rst_n),
      .wr_addr  (sel && (cfg_tgt_e'(cfg_sel_ctrl) == CFG_TGT_ADDR)),
      .wr_ctrl  (sel && (cfg_tgt_e'(cfg_sel_ctrl) == CFG_TGT_CTRL)),
      .wdata    (cfg_wdata),
      .bp_addr  (s_addr),
      .bp_mask  (s_mask),
      .bp_st_en (s_st),
      .bp_ld_en (s_ld)
    );

    dbm_match #(.ADDR_W(ADDR_W)) u_match (
      .acc_valid (acc_valid),
      .acc_addr  (acc_addr),
      .acc_store (acc_store),
      .bp_addr   (s_addr),
      .bp_mask   (s_mask),
      .bp_st_en  (s_st),
      .bp_ld_en  (s_ld),
      .hit       (hit_vec[i])
    );
  end

  assign hit_any = |hit_vec;

endmodule

// File: rtl/dbm_watch_chk.sv
module dbm_watch_chk #(
  parameter int unsigned NUM_BP = 2,
  parameter int unsigned IDX_W  = 1
) (
  input logic              clk,
  input logic              rst_n,
  input logic              cfg_we,
  input logic [IDX_W-1:0]  cfg_idx,
  input logic              cfg_sel_ctrl,
  input logic              cfg_st_bit,
  input logic              cfg_ld_bit,
  input logic              acc_valid,
  input logic              acc_store,
  input logic [NUM_BP-1:0] hit_vec,
  input logic              hit_any
);

  logic any_ctrl_written;

  always_ff @(posedge clk) begin
    if (!rst_n) any_ctrl_written <= 1'b0;
    else if (cfg_we && cfg_sel_ctrl) any_ctrl_written <= 1'b1;
  end

  // R1: quiet until some control register has been written
  assert_quiet_after_reset_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !any_ctrl_written |-> (hit_vec == '0));

  // R7: nothing reported without a valid access
  assert_idle_no_hit_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !acc_valid |-> (hit_vec == '0) && !hit_any);

  // R8: combined output agrees with the per-slot vector
  assert_any_agrees_R8: assert property (@(posedge clk) disable iff (!rst_n)
    hit_any == ($countones(hit_vec) != 0));

  for (genvar i = 0; i < NUM_BP; i++) begin : g_chk
    logic seen_st;
    logic seen_ld;
    logic wr_here;

    assign wr_here = cfg_we && cfg_sel_ctrl && (cfg_idx == IDX_W'(i));

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        seen_st <= 1'b0;
        seen_ld <= 1'b0;
      end else if (wr_here) begin
        seen_st <= cfg_st_bit;
        seen_ld <= cfg_ld_bit;
      end
    end

    // R3: store hits require the store enable last written
    assert_store_gated_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (acc_valid && acc_store && hit_vec[i]) |-> seen_st);

    // R4: load hits require the load enable last written
    assert_load_gated_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (acc_valid && !acc_store && hit_vec[i]) |-> seen_ld);

    // R2, R9: disabling a slot silences it from the next cycle
    assert_disable_next_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_here && !cfg_st_bit && !cfg_ld_bit) |=> !hit_vec[i]);
  end

endmodule

bind dbm_watch dbm_watch_chk #(
  .NUM_BP (NUM_BP),
  .IDX_W  ($clog2(NUM_BP > 1 ? NUM_BP : 2))
) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .cfg_we       (cfg_we),
  .cfg_idx      (cfg_idx),
  .cfg_sel_ctrl (cfg_sel_ctrl),
  .cfg_st_bit   (cfg_wdata[ADDR_W-1]),
  .cfg_ld_bit   (cfg_wdata[ADDR_W-2]),
  .acc_valid    (acc_valid),
  .acc_store    (acc_store),
  .hit_vec      (hit_vec),
  .hit_any      (hit_any)
);

// File: tb/dbm_watch_test.sv
module dbm_watch_test;

  localparam int CLK_PERIOD = 10;
  localparam int NB = 2;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_we = 1'b0;
  logic [0:0]  cfg_idx = '0;
  logic        cfg_sel_ctrl = 1'b0;
  logic [31:0] cfg_wdata = '0;
  logic        acc_valid = 1'b0;
  logic [31:0] acc_addr = '0;
  logic        acc_store = 1'b0;
  logic [NB-1:0] hit_vec;
  logic        hit_any;

  int checks = 0;
  int errors = 0;

  logic [31:0] m_addr [NB];
  logic [31:0] m_ctrl [NB];

  always #(CLK_PERIOD/2) clk = ~clk;

  dbm_watch #(.NUM_BP(NB), .ADDR_W(32), .MASK_W(6)) uut (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_idx(cfg_idx),
    .cfg_sel_ctrl(cfg_sel_ctrl), .cfg_wdata(cfg_wdata),
    .acc_valid(acc_valid), .acc_addr(acc_addr), .acc_store(acc_store),
    .hit_vec(hit_vec), .hit_any(hit_any)
  );

  function automatic logic [31:0] eff_mask(logic [31:0] ctrl);
    logic [31:0] m;
    logic run;
    m = 32'hFFFF_FFC0;
    run = 1'b1;
    for (int b = 5; b >= 0; b--) begin
      run = run & ctrl[b];
      m[b] = run;
    end
    return m;
  endfunction

  function automatic logic [NB-1:0] exp_hits(logic v, logic [31:0] a, logic st);
    logic [NB-1:0] h;
    for (int i = 0; i < NB; i++) begin
      logic en;
      en = st ? m_ctrl[i][31] : m_ctrl[i][30];
      h[i] = v && en && (((a ^ m_addr[i]) & eff_mask(m_ctrl[i])) == 32'h0);
    end
    return h;
  endfunction

  task automatic check_now(string tag, logic [NB-1:0] exp);
    checks++;
    if (hit_vec !== exp || hit_any !== (exp != '0)) begin
      errors++;
      $display("FAIL %s: hit_vec=%b hit_any=%b expected hit_vec=%b hit_any=%b",
               tag, hit_vec, hit_any, exp, (exp != '0));
    end
  endtask

  task automatic cfg_write(int idx, bit is_ctrl, logic [31:0] d);
    @(negedge clk);
    cfg_we = 1'b1; cfg_idx = idx[0:0]; cfg_sel_ctrl = is_ctrl; cfg_wdata = d;
    @(posedge clk); #1;
    cfg_we = 1'b0;
    if (is_ctrl) m_ctrl[idx] = d; else m_addr[idx] = d;
  endtask

  task automatic probe(string tag, logic [31:0] a, bit st, bit v);
    @(negedge clk);
    acc_valid = v; acc_addr = a; acc_store = st;
    #1;
    check_now(tag, exp_hits(v, a, st));
    acc_valid = 1'b0;
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    errors++;
    $display("FAIL watchdog: run did not complete, actual=hung expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    void'($urandom(32'd5417));
    for (int i = 0; i < NB; i++) begin m_addr[i] = '0; m_ctrl[i] = '0; end
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;

    // R1: reset state, nothing enabled
    probe("R1 reset load", 32'h0000_0000, 1'b0, 1'b1);
    probe("R1 reset store", 32'h0000_0000, 1'b1, 1'b1);

    // Slot 0: exact byte, store only
    cfg_write(0, 0, 32'h1000_0040);
    cfg_write(0, 1, 32'h8000_003F);
    probe("R3 R5 exact store hit", 32'h1000_0040, 1'b1, 1'b1);
    probe("R4 load with store-only", 32'h1000_0040, 1'b0, 1'b1);
    probe("R5 neighbour byte miss", 32'h1000_0041, 1'b1, 1'b1);
    probe("R7 valid low", 32'h1000_0040, 1'b1, 1'b0);

    // 8-byte region
    cfg_write(0, 1, 32'h8000_0038);
    probe("R5 8B top hit", 32'h1000_0047, 1'b1, 1'b1);
    probe("R5 8B past end", 32'h1000_0048, 1'b1, 1'b1);

    // Non-contiguous field trimmed to 16 bytes
    cfg_write(0, 1, 32'h8000_0035);
    probe("R6 trimmed hit", 32'h1000_0044, 1'b1, 1'b1);
    probe("R6 trimmed top", 32'h1000_004F, 1'b1, 1'b1);
    probe("R6 trimmed miss", 32'h1000_0050, 1'b1, 1'b1);

    // Load only, whole 64B block
    cfg_write(0, 1, 32'h4000_0000);
    probe("R4 load hit", 32'h1000_007F, 1'b0, 1'b1);
    probe("R3 store with load-only", 32'h1000_007F, 1'b1, 1'b1);

    // R10: slot 1 programmed, slot 0 unchanged
    cfg_write(1, 0, 32'h1000_0060);
    cfg_write(1, 1, 32'hC000_003C);
    probe("R8 R10 both slots hit", 32'h1000_0062, 1'b0, 1'b1);
    cfg_write(0, 0, 32'h2000_0000);
    probe("R10 slot1 kept after slot0 addr write", 32'h1000_0062, 1'b0, 1'b1);
    probe("R10 slot0 ctrl kept", 32'h2000_0010, 1'b0, 1'b1);

    // R2: neither enable
    cfg_write(1, 1, 32'h0000_003F);
    probe("R2 no enable load", 32'h1000_0060, 1'b0, 1'b1);
    probe("R2 no enable store", 32'h1000_0060, 1'b1, 1'b1);

    // R9 R11: write and access in the same cycle see old value
    @(negedge clk);
    cfg_we = 1'b1; cfg_idx = 1'b1; cfg_sel_ctrl = 1'b1; cfg_wdata = 32'h8000_003F;
    acc_valid = 1'b1; acc_addr = 32'h1000_0060; acc_store = 1'b1;
    #1;
    check_now("R9 same-cycle old value", exp_hits(1'b1, 32'h1000_0060, 1'b1));
    @(posedge clk); #1;
    cfg_we = 1'b0;
    m_ctrl[1] = 32'h8000_003F;
    check_now("R9 R11 next-cycle new value", exp_hits(1'b1, 32'h1000_0060, 1'b1));
    acc_valid = 1'b0;

    // Constrained random mix
    for (int n = 0; n < 400; n++) begin
      int unsigned r;
      r = $urandom % 8;
      if (r == 0) begin
        int unsigned s;
        logic [31:0] d;
        s = $urandom % NB;
        d = $urandom;
        d[29:6] = '0;
        cfg_write(int'(s), 1, d);
      end else if (r == 1) begin
        int unsigned s;
        s = $urandom % NB;
        cfg_write(int'(s), 0, $urandom);
      end else begin
        logic [31:0] a;
        int unsigned s;
        s = $urandom % NB;
        a = ($urandom % 2 == 0) ? (m_addr[s] ^ ($urandom & 32'h3F)) : $urandom;
        probe("R5 random", a, 1'($urandom), ($urandom % 6) != 0);
      end
    end

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule